// File: doc/BRIEF.md
# Rotating-Top Floating-Point Register Stack

This block holds eight extended-precision floating-point registers addressed relative to a rotating top-of-stack pointer, with one occupancy tag per entry. A stack-relative name ST(i) resolves to physical slot (TOP + i) mod 8. The block takes the two-byte register form of the floating-point multiply group, resolves both operands and the destination to physical slots, and shows the two operand values on read ports for an external multiplier. When the multiplier returns its result on the write-back port, the block stores it in the destination and, for the popping variant, retires the old top in the same clock edge.

Control is a two-state machine. `ST_IDLE` accepts an instruction or a stack load. The transition *issue* (legal opcode, both operands occupied) moves to `ST_WAIT`. A legal opcode that names an empty slot raises the underflow flag and stays in `ST_IDLE` (transition *fault*). `ST_WAIT` holds the operand ports steady until the transition *retire* (write-back strobe) returns to `ST_IDLE`. A load port pushes values so that tests and the surrounding pipeline can fill the stack.

Top module: `fpstk_top`

## Requirements
- R1: After reset, TOP is 0, all eight tags are empty, and busy, underflow and C1 are all 0.
- R2: In idle with `load_valid` high and `op_valid` low, TOP drops by one (mod 8), and the value is written to the new ST(0), which is tagged occupied. A load is ignored while busy or when `op_valid` is also high.
- R3: An instruction is legal when `op_hi` is 0xD8, 0xDC or 0xDE and `op_lo[7:3]` is 5'b11001. The index i is `op_lo[2:0]`. While busy, `opnd_top_data` shows ST(0) and `opnd_idx_data` shows ST(i), with ST(i) at physical slot (TOP+i) mod 8. For 0xD8 the result goes to ST(0) and there is no pop.
- R4: For 0xDC the result goes to ST(i), and TOP and the tags other than the destination stay unchanged.
- R5: For 0xDE the result goes to ST(i) and the stack is popped afterwards. 0xDE 0xC9 writes ST(1).
- R6: A pop happens on the same edge as the result write. It empties the slot at the TOP value held before that edge, then TOP increments (mod 8). When the destination is that slot, the slot ends up empty.
- R7: If ST(0) or ST(i) is empty when a legal instruction is presented in idle, `stk_underflow` goes to 1 and C1 goes to 0. No busy period, write or pop follows, and TOP and the tags stay unchanged. The flag holds until the next legal instruction is accepted.
- R8: On the write-back edge of a successful instruction, C1 takes the value of `wb_round_up`.
- R9: An illegal opcode pair has no effect on state, flags or C1.
- R10: A write-back strobe while idle has no effect.
- R11: While busy, new instructions and loads are ignored. The block leaves busy only on a write-back strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_valid | input | 1 | Push request |
| load_data | input | DATA_W | Value to push |
| op_valid | input | 1 | Instruction present |
| op_hi | input | 8 | First opcode byte |
| op_lo | input | 8 | Second opcode byte |
| wb_valid | input | 1 | Result write-back strobe |
| wb_data | input | DATA_W | Product to store |
| wb_round_up | input | 1 | Result was rounded up |
| busy | output | 1 | Instruction issued, waiting for write-back |
| opnd_top_data | output | DATA_W | Value of ST(0) for the issued instruction |
| opnd_idx_data | output | DATA_W | Value of ST(i) for the issued instruction |
| stk_underflow | output | 1 | Last accepted instruction hit an empty slot |
| c1 | output | 1 | Condition bit C1 |
| top_ptr | output | 3 | Current TOP |
| tag_vec | output | 8 | Occupancy tag per physical slot |

## Verification
If TOP slips by one, the fault shows on the next issue: the operand ports present the wrong value, and later lookups select the wrong tag. So one extra cycle is enough to expose a bad pop or push. A tag left set or cleared in error shows up either as an underflow that should not happen or as a missing one on the next instruction that names the slot. A result written to the wrong slot stays hidden until a later instruction reads that slot through the operand ports. For this reason the directed sequence reads back every destination it writes.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ctl_state_t;

    localparam logic [7:0] OPC_MUL_TO_TOP  = 8'hD8;
    localparam logic [7:0] OPC_MUL_TO_IDX  = 8'hDC;
    localparam logic [7:0] OPC_MUL_POP     = 8'hDE;
    localparam logic [4:0] REG_FORM_PREFIX = 5'b11001;
endpackage

// File: rtl/fpstk_decode.sv
module fpstk_decode
    import fpstk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [7:0]       op_hi,
    input  logic [7:0]       op_lo,
    input  logic [PTR_W-1:0] top,
    input  logic [DEPTH-1:0] tags,
    output logic             legal,
    output logic             pop,
    output logic             underflow,
    output logic [PTR_W-1:0] top_phys,
    output logic [PTR_W-1:0] idx_phys,
    output logic [PTR_W-1:0] dst_phys
);
    logic dst_is_idx;
    logic reg_form;

    always_comb begin
        reg_form   = (op_lo[7:3] == REG_FORM_PREFIX);
        top_phys   = top;
        idx_phys   = top + PTR_W'(op_lo[2:0]);
        legal      = 1'b0;
        pop        = 1'b0;
        dst_is_idx = 1'b0;
        case (op_hi)
            OPC_MUL_TO_TOP: legal = reg_form;
            OPC_MUL_TO_IDX: begin
                legal      = reg_form;
                dst_is_idx = 1'b1;
            end
            OPC_MUL_POP: begin
                legal      = reg_form;
                dst_is_idx = 1'b1;
                pop        = 1'b1;
            end
            default: legal = 1'b0;
        endcase
        dst_phys  = dst_is_idx ? idx_phys : top_phys;
        underflow = legal && (!tags[top_phys] || !tags[idx_phys]);
    end
endmodule

// File: rtl/fpstk_regs.sv
module fpstk_regs #(
    parameter int DATA_W = 80,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop_en,
    input  logic [PTR_W-1:0]  rd_a_idx,
    input  logic [PTR_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    output logic [PTR_W-1:0]  top,
    output logic [DEPTH-1:0]  tags
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  top_dn;

    assign top_dn    = top - PTR_W'(1);
    assign rd_a_data = mem[rd_a_idx];
    assign rd_b_data = mem[rd_b_idx];

    always_ff @(posedge clk) begin
        if (push_en) begin
            mem[top_dn] <= push_data;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top  <= '0;
            tags <= '0;
        end else if (push_en) begin
            top          <= top_dn;
            tags[top_dn] <= 1'b1;
        end else begin
            if (wr_en) begin
                tags[wr_idx] <= 1'b1;
            end
            if (pop_en) begin
                tags[top] <= 1'b0;
                top       <= top + PTR_W'(1);
            end
        end
    end
endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
    import fpstk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             load_valid,
    input  logic             dec_legal,
    input  logic             dec_pop,
    input  logic             dec_underflow,
    input  logic [PTR_W-1:0] dec_top_phys,
    input  logic [PTR_W-1:0] dec_idx_phys,
    input  logic [PTR_W-1:0] dec_dst_phys,
    input  logic             wb_valid,
    input  logic             wb_round_up,
    output logic             busy,
    output logic             push_en,
    output logic             wr_en,
    output logic             pop_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_a_idx,
    output logic [PTR_W-1:0] rd_b_idx,
    output logic             pend_pop,
    output logic             underflow,
    output logic             c1
);
    ctl_state_t state, state_nx;
    logic       accept;
    logic       issue;
    logic       retire;

    assign accept = (state == ST_IDLE) && op_valid && dec_legal;
    assign issue  = accept && !dec_underflow;
    assign retire = (state == ST_WAIT) && wb_valid;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (issue)  state_nx = ST_WAIT;
            ST_WAIT: if (retire) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx    <= '0;
            rd_a_idx  <= '0;
            rd_b_idx  <= '0;
            pend_pop  <= 1'b0;
            underflow <= 1'b0;
            c1        <= 1'b0;
        end else if (accept) begin
            underflow <= dec_underflow;
            if (dec_underflow) begin
                c1 <= 1'b0;
            end else begin
                wr_idx   <= dec_dst_phys;
                rd_a_idx <= dec_top_phys;
                rd_b_idx <= dec_idx_phys;
                pend_pop <= dec_pop;
            end
        end else if (retire) begin
            c1 <= wb_round_up;
        end
    end

    always_comb begin
        busy    = 1'b0;
        push_en = 1'b0;
        wr_en   = 1'b0;
        pop_en  = 1'b0;
        unique case (state)
            ST_IDLE: push_en = load_valid && !op_valid;
            ST_WAIT: begin
                busy   = 1'b1;
                wr_en  = wb_valid;
                pop_en = wb_valid && pend_pop;
            end
        endcase
    end
endmodule

// File: rtl/fpstk_top.sv
module fpstk_top #(
    parameter int DATA_W = 80,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    input  logic              op_valid,
    input  logic [7:0]        op_hi,
    input  logic [7:0]        op_lo,
    input  logic              wb_valid,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              wb_round_up,
    output logic              busy,
    output logic [DATA_W-1:0] opnd_top_data,
    output logic [DATA_W-1:0] opnd_idx_data,
    output logic              stk_underflow,
    output logic              c1,
    output logic [PTR_W-1:0]  top_ptr,
    output logic [DEPTH-1:0]  tag_vec
);
    logic             dec_legal, dec_pop, dec_underflow;
    logic [PTR_W-1:0] dec_top_phys, dec_idx_phys, dec_dst_phys;
    logic             push_en, wr_en, pop_en, pend_pop;
    logic [PTR_W-1:0] wr_idx, rd_a_idx, rd_b_idx;

    fpstk_decode #(.DEPTH(DEPTH)) u_dec (
        .op_hi     (op_hi),
        .op_lo     (op_lo),
        .top       (top_ptr),
        .tags      (tag_vec),
        .legal     (dec_legal),
        .pop       (dec_pop),
        .underflow (dec_underflow),
        .top_phys  (dec_top_phys),
        .idx_phys  (dec_idx_phys),
        .dst_phys  (dec_dst_phys)
    );

    fpstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .load_valid    (load_valid),
        .dec_legal     (dec_legal),
        .dec_pop       (dec_pop),
        .dec_underflow (dec_underflow),
        .dec_top_phys  (dec_top_phys),
        .dec_idx_phys  (dec_idx_phys),
        .dec_dst_phys  (dec_dst_phys),
        .wb_valid      (wb_valid),
        .wb_round_up   (wb_round_up),
        .busy          (busy),
        .push_en       (push_en),
        .wr_en         (wr_en),
        .pop_en        (pop_en),
        .wr_idx        (wr_idx),
        .rd_a_idx      (rd_a_idx),
        .rd_b_idx      (rd_b_idx),
        .pend_pop      (pend_pop),
        .underflow     (stk_underflow),
        .c1            (c1)
    );

    fpstk_regs #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_data (load_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wb_data),
        .pop_en    (pop_en),
        .rd_a_idx  (rd_a_idx),
        .rd_b_idx  (rd_b_idx),
        .rd_a_data (opnd_top_data),
        .rd_b_data (opnd_idx_data),
        .top       (top_ptr),
        .tags      (tag_vec)
    );
endmodule

// File: rtl/fpstk_chk.sv
module fpstk_chk #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_valid,
    input logic             op_valid,
    input logic             wb_valid,
    input logic             wb_round_up,
    input logic             busy,
    input logic             stk_underflow,
    input logic             c1,
    input logic             pend_pop,
    input logic [PTR_W-1:0] top_ptr,
    input logic [DEPTH-1:0] tag_vec
);
    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load_valid && !op_valid) |=> (top_ptr == PTR_W'($past(top_ptr) - 1'b1))); // R2
    AST_PUSH_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load_valid && !op_valid) |=> tag_vec[top_ptr]); // R2
    AST_NOPOP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wb_valid && !pend_pop) |=> $stable(top_ptr)); // R4
    AST_POP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wb_valid && pend_pop) |=> (top_ptr == PTR_W'($past(top_ptr) + 1'b1))); // R6
    AST_POP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wb_valid && pend_pop) |=> !tag_vec[$past(top_ptr)]); // R6
    AST_UFL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stk_underflow |-> (!busy && !c1)); // R7
    AST_UFL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_underflow) |-> ($stable(top_ptr) && $stable(tag_vec))); // R7
    AST_C1_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wb_valid) |=> (c1 == $past(wb_round_up))); // R8
    AST_WB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wb_valid && !load_valid && !op_valid) |=> ($stable(top_ptr) && $stable(tag_vec))); // R10
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wb_valid) |=> (busy && $stable(top_ptr) && $stable(tag_vec))); // R11
endmodule

bind fpstk_top fpstk_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_valid    (load_valid),
    .op_valid      (op_valid),
    .wb_valid      (wb_valid),
    .wb_round_up   (wb_round_up),
    .busy          (busy),
    .stk_underflow (stk_underflow),
    .c1            (c1),
    .pend_pop      (pend_pop),
    .top_ptr       (top_ptr),
    .tag_vec       (tag_vec)
);

// File: tb/sim_fpstk_top.sv
`timescale 1ns/1ps
module sim_fpstk_top;
    localparam int DATA_W = 80;

    typedef struct packed {
        logic [1:0]  kind;   // 0 load, 1 op, 2 write-back
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic [15:0] val;
        logic        ru;
        logic [2:0]  etop;
        logic [7:0]  etag;
        logic        ebusy;
        logic        eufl;
        logic        ec1;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 8'hD8, 8'hC9, 16'h0000, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0}, // R7 empty stack
        '{2'd0, 8'h00, 8'h00, 16'h0011, 1'b0, 3'd7, 8'h80, 1'b0, 1'b1, 1'b0}, // R2 wrap 0->7
        '{2'd0, 8'h00, 8'h00, 16'h0022, 1'b0, 3'd6, 8'hC0, 1'b0, 1'b1, 1'b0}, // R2
        '{2'd0, 8'h00, 8'h00, 16'h0033, 1'b0, 3'd5, 8'hE0, 1'b0, 1'b1, 1'b0}, // R2
        '{2'd1, 8'hD8, 8'hC9, 16'h0000, 1'b0, 3'd5, 8'hE0, 1'b1, 1'b0, 1'b0}, // R3 issue
        '{2'd2, 8'h00, 8'h00, 16'h00AA, 1'b1, 3'd5, 8'hE0, 1'b0, 1'b0, 1'b1}, // R8
        '{2'd1, 8'hDC, 8'hCA, 16'h0000, 1'b0, 3'd5, 8'hE0, 1'b1, 1'b0, 1'b1}, // R4
        '{2'd2, 8'h00, 8'h00, 16'h00BB, 1'b0, 3'd5, 8'hE0, 1'b0, 1'b0, 1'b0}, // R4 R8
        '{2'd1, 8'hDE, 8'hC9, 16'h0000, 1'b0, 3'd5, 8'hE0, 1'b1, 1'b0, 1'b0}, // R5
        '{2'd2, 8'h00, 8'h00, 16'h00CC, 1'b1, 3'd6, 8'hC0, 1'b0, 1'b0, 1'b1}, // R5 R6
        '{2'd1, 8'hD8, 8'hCB, 16'h0000, 1'b0, 3'd6, 8'hC0, 1'b0, 1'b1, 1'b0}, // R7
        '{2'd1, 8'h00, 8'hC8, 16'h0000, 1'b0, 3'd6, 8'hC0, 1'b0, 1'b1, 1'b0}, // R9
        '{2'd1, 8'hD8, 8'hC0, 16'h0000, 1'b0, 3'd6, 8'hC0, 1'b0, 1'b1, 1'b0}, // R9
        '{2'd2, 8'h00, 8'h00, 16'h00DD, 1'b1, 3'd6, 8'hC0, 1'b0, 1'b1, 1'b0}, // R10
        '{2'd1, 8'hD8, 8'hC8, 16'h0000, 1'b0, 3'd6, 8'hC0, 1'b1, 1'b0, 1'b0}, // R3
        '{2'd1, 8'hDE, 8'hC9, 16'h0000, 1'b0, 3'd6, 8'hC0, 1'b1, 1'b0, 1'b0}, // R11
        '{2'd0, 8'h00, 8'h00, 16'h0055, 1'b0, 3'd6, 8'hC0, 1'b1, 1'b0, 1'b0}, // R11 R2
        '{2'd2, 8'h00, 8'h00, 16'h00EE, 1'b0, 3'd6, 8'hC0, 1'b0, 1'b0, 1'b0}, // R3
        '{2'd1, 8'hDE, 8'hC9, 16'h0000, 1'b0, 3'd6, 8'hC0, 1'b1, 1'b0, 1'b0}, // R5
        '{2'd2, 8'h00, 8'h00, 16'h0077, 1'b0, 3'd7, 8'h80, 1'b0, 1'b0, 1'b0}, // R6
        '{2'd1, 8'hDE, 8'hC8, 16'h0000, 1'b0, 3'd7, 8'h80, 1'b1, 1'b0, 1'b0}, // R6
        '{2'd2, 8'h00, 8'h00, 16'h0099, 1'b1, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1}  // R6 wrap
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_valid = 1'b0;
    logic [DATA_W-1:0] load_data = '0;
    logic              op_valid = 1'b0;
    logic [7:0]        op_hi = '0;
    logic [7:0]        op_lo = '0;
    logic              wb_valid = 1'b0;
    logic [DATA_W-1:0] wb_data = '0;
    logic              wb_round_up = 1'b0;
    logic              busy;
    logic [DATA_W-1:0] opnd_top_data;
    logic [DATA_W-1:0] opnd_idx_data;
    logic              stk_underflow;
    logic              c1;
    logic [2:0]        top_ptr;
    logic [7:0]        tag_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    fpstk_top #(.DATA_W(DATA_W), .DEPTH(8)) u0 (
        .clk(clk), .rst_n(rst_n),
        .load_valid(load_valid), .load_data(load_data),
        .op_valid(op_valid), .op_hi(op_hi), .op_lo(op_lo),
        .wb_valid(wb_valid), .wb_data(wb_data), .wb_round_up(wb_round_up),
        .busy(busy), .opnd_top_data(opnd_top_data), .opnd_idx_data(opnd_idx_data),
        .stk_underflow(stk_underflow), .c1(c1), .top_ptr(top_ptr), .tag_vec(tag_vec)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] kind, input logic [7:0] hi, input logic [7:0] lo,
                        input logic [DATA_W-1:0] val, input logic ru);
        @(negedge clk);
        load_valid  = (kind == 2'd0);
        op_valid    = (kind == 2'd1);
        wb_valid    = (kind == 2'd2);
        load_data   = val;
        wb_data     = val;
        wb_round_up = ru;
        op_hi       = hi;
        op_lo       = lo;
        @(posedge clk);
        #1;
        load_valid = 1'b0;
        op_valid   = 1'b0;
        wb_valid   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 top",   DATA_W'(top_ptr),       '0);
        check("R1 tags",  DATA_W'(tag_vec),       '0);
        check("R1 busy",  DATA_W'(busy),          '0);
        check("R1 ufl",   DATA_W'(stk_underflow), '0);
        check("R1 c1",    DATA_W'(c1),            '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        do_reset();

        for (int k = 0; k < NV; k++) begin
            step(VEC[k].kind, VEC[k].hi, VEC[k].lo, DATA_W'(VEC[k].val), VEC[k].ru);
            check($sformatf("vec%0d top", k),  DATA_W'(top_ptr),       DATA_W'(VEC[k].etop));
            check($sformatf("vec%0d tags", k), DATA_W'(tag_vec),       DATA_W'(VEC[k].etag));
            check($sformatf("vec%0d busy", k), DATA_W'(busy),          DATA_W'(VEC[k].ebusy));
            check($sformatf("vec%0d ufl", k),  DATA_W'(stk_underflow), DATA_W'(VEC[k].eufl));
            check($sformatf("vec%0d c1", k),   DATA_W'(c1),            DATA_W'(VEC[k].ec1));
        end

        // Directed: operand mapping and destination read-back
        do_reset();
        step(2'd0, 8'h00, 8'h00, 80'h101, 1'b0);
        step(2'd0, 8'h00, 8'h00, 80'h202, 1'b0);
        step(2'd0, 8'h00, 8'h00, 80'h303, 1'b0);
        step(2'd1, 8'hDC, 8'hCA, '0, 1'b0);
        check("R3 st0 operand", opnd_top_data, 80'h303);
        check("R3 st2 operand", opnd_idx_data, 80'h101);
        step(2'd2, 8'h00, 8'h00, 80'h444, 1'b0);
        step(2'd1, 8'hD8, 8'hCA, '0, 1'b0);
        check("R4 dest st2 written", opnd_idx_data, 80'h444);
        check("R4 st0 untouched",    opnd_top_data, 80'h303);
        step(2'd2, 8'h00, 8'h00, 80'h555, 1'b0);
        step(2'd1, 8'hDE, 8'hC9, '0, 1'b0);
        check("R3 dest st0 written", opnd_top_data, 80'h555);
        check("R5 st1 operand",      opnd_idx_data, 80'h202);
        step(2'd2, 8'h00, 8'h00, 80'h666, 1'b0);
        check("R6 top after pop", DATA_W'(top_ptr), DATA_W'(3'd6));
        step(2'd1, 8'hD8, 8'hC9, '0, 1'b0);
        check("R5 st1 result now st0", opnd_top_data, 80'h666);
        check("R6 new st1",            opnd_idx_data, 80'h444);
        step(2'd1, 8'hD8, 8'hC8, '0, 1'b0);
        check("R11 operand held", opnd_idx_data, 80'h444);

        // Reset while busy
        do_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule